// File: doc/BRIEF.md
# Locked-Sequence Request Arbiter

This block sits between several requesters and one shared completer and decides, cycle by cycle, which requester may issue its next transaction. Each requester offers a request together with a 2-bit lock attribute. It also returns a one-cycle pulse whenever one of its issued transactions finishes. Outside of locked sequences the arbiter rotates fairly among the requesters that are asking, and it keeps a count of transactions in flight for each requester.

A request carrying the locked attribute opens a locked sequence. From then on only that requester can be served. The sequence closes with the owner's first request that is not locked. That closing transaction is still served to the owner. After it nobody is served until every transaction of the owner has finished. Then the lock drops and normal rotation resumes. A locked request is held back while its requester still has transactions in flight. The exclusive code is served like a plain request. The unused fourth code is served like a plain request but raises a sticky error flag.

Grants are combinational from the request inputs, so a request is accepted in the same cycle that its grant bit is high. The requester holds its request until it sees that grant.

Top module: `lockseq_arbiter`

## Requirements
- R1: `grant` is one-hot or zero. A grant bit is high only for a requester whose `req_valid` bit is high, and that request counts as accepted on the same clock edge.
- R2: Outside a locked sequence the search for a winner starts at the requester after the last one granted, wrapping from N-1 to 0, and the first eligible requester found wins.
- R3: A request with lock code 2'b10 (locked), from a requester whose in-flight count is not zero, is not granted. It becomes eligible in the cycle after the count reaches zero.
- R4: When a locked (2'b10) request is granted while no sequence is open, `lock_held` is 1 from the next cycle and `lock_owner` gives that requester's index.
- R5: While `lock_held` is 1, no requester other than `lock_owner` is granted, and `lock_owner` does not change.
- R6: The owner's first granted request with a code other than 2'b10 (2'b00, 2'b01 or 2'b11) closes the sequence. From the next cycle until release, no requester is granted.
- R7: After the closing grant, `lock_held` falls in the cycle after the edge at which the owner's in-flight count reaches zero. Other requesters can be granted in that same cycle.
- R8: A requester's in-flight count rises by one on each grant and falls by one on each `txn_done` pulse. A pulse at count zero is ignored. A requester whose count is at its maximum (2^CNT_W-1) is not granted.
- R9: A granted request with the reserved code 2'b11 is served as a plain request and sets `lock_err` from the next cycle. `lock_err` then stays at 1 until reset.
- R10: The exclusive code 2'b01 is arbitrated exactly like the plain code 2'b00 and never opens a sequence.
- R11: During and right after reset, `grant` is 0, `lock_held` is 0, `lock_owner` is 0 and `lock_err` is 0. The rotation starts at requester 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | N | Per-requester request present |
| req_lock | input | 2*N | Per-requester lock code, requester i in bits [2i+1:2i] |
| txn_done | input | N | Per-requester one-cycle completion pulse |
| grant | output | N | One-hot acceptance of a request this cycle |
| lock_held | output | 1 | A locked sequence is open or draining |
| lock_owner | output | $clog2(N) | Index of the lock owner, 0 when no lock is held |
| lock_err | output | 1 | Sticky flag: a reserved lock code was served |

## Verification
The grant answers the request inputs in the same cycle. Every other result is due one edge later: the lock flag and owner, the error flag, the in-flight counts (seen through whether a locked or saturated request is served), and the release of a drained lock. The bench changes inputs only on the falling edge and compares all four outputs 2 ns later against a behavioural model. The model has not yet taken the coming edge at that point, so each comparison matches the cycle in which the result is due. Directed phases push each corner on purpose: a locked request behind busy work, a full sequence with competing requesters, a closing grant followed by a drain, counter saturation with surplus completion pulses, and the reserved code. A long mixed phase follows them.

// File: rtl/lockseq_pkg.sv
package lockseq_pkg;

    typedef enum logic [1:0] {
        LOCK_NORMAL = 2'b00,
        LOCK_EXCL   = 2'b01,
        LOCK_SEQ    = 2'b10,
        LOCK_RSVD   = 2'b11
    } lock_code_e;

    typedef enum logic [1:0] {
        SEQ_OPEN  = 2'd0,
        SEQ_HELD  = 2'd1,
        SEQ_DRAIN = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic zero;
        logic full;
        logic zero_next;
    } ctr_flags_t;

    function automatic logic starts_lock(input logic [1:0] code);
        return code == LOCK_SEQ;
    endfunction

    function automatic logic is_reserved(input logic [1:0] code);
        return code == LOCK_RSVD;
    endfunction

endpackage

// File: rtl/lockseq_outst_ctr.sv
module lockseq_outst_ctr
    import lockseq_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       inc,
    input  logic       dec,
    output ctr_flags_t flags
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             inc_eff;
    logic             dec_eff;

    // Guard both ends: never wrap past full or below zero.
    assign inc_eff = inc && (cnt_q != CNT_MAX);
    assign dec_eff = dec && (cnt_q != '0);

    always_comb begin
        unique case ({inc_eff, dec_eff})
            2'b10:   cnt_d = cnt_q + 1'b1;
            2'b01:   cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign flags.zero      = (cnt_q == '0);
    assign flags.full      = (cnt_q == CNT_MAX);
    assign flags.zero_next = (cnt_d == '0);

endmodule

// File: rtl/lockseq_rr_pick.sv
module lockseq_rr_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     elig,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] win_idx,
    output logic             win_any
);
    localparam logic [N-1:0] ONE_HOT0 = {{(N-1){1'b0}}, 1'b1};

    logic [IDX_W-1:0] ptr_q;

    // Scan from the rotation pointer, take the first eligible requester.
    always_comb begin
        win_any = 1'b0;
        win_idx = '0;
        for (int off = 0; off < N; off++) begin
            if (!win_any && elig[(int'(ptr_q) + off) % N]) begin
                win_any = 1'b1;
                win_idx = IDX_W'((int'(ptr_q) + off) % N);
            end
        end
        gnt = win_any ? (ONE_HOT0 << win_idx) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (win_any) begin
            ptr_q <= (win_idx == IDX_W'(N - 1)) ? '0 : win_idx + 1'b1;
        end
    end

endmodule

// File: rtl/lockseq_seq_ctl.sv
module lockseq_seq_ctl
    import lockseq_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             win_any,
    input  logic [IDX_W-1:0] win_idx,
    input  logic [1:0]       win_code,
    input  logic [N-1:0]     zero_next,
    output seq_state_e       seq_q,
    output logic [IDX_W-1:0] owner_q
);
    seq_state_e       seq_d;
    logic [IDX_W-1:0] owner_d;

    always_comb begin
        seq_d   = seq_q;
        owner_d = owner_q;
        unique case (seq_q)
            SEQ_OPEN: begin
                if (win_any && starts_lock(win_code)) begin
                    seq_d   = SEQ_HELD;
                    owner_d = win_idx;
                end
            end
            SEQ_HELD: begin
                if (win_any && (win_idx == owner_q) && !starts_lock(win_code)) begin
                    seq_d = SEQ_DRAIN;
                end
            end
            SEQ_DRAIN: begin
                if (zero_next[owner_q]) begin
                    seq_d   = SEQ_OPEN;
                    owner_d = '0;
                end
            end
            default: seq_d = SEQ_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q   <= SEQ_OPEN;
            owner_q <= '0;
        end else begin
            seq_q   <= seq_d;
            owner_q <= owner_d;
        end
    end

endmodule

// File: rtl/lockseq_arbiter.sv
module lockseq_arbiter
    import lockseq_pkg::*;
#(
    parameter  int N     = 4,
    parameter  int CNT_W = 3,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     req_valid,
    input  logic [2*N-1:0]   req_lock,
    input  logic [N-1:0]     txn_done,
    output logic [N-1:0]     grant,
    output logic             lock_held,
    output logic [IDX_W-1:0] lock_owner,
    output logic             lock_err
);
    ctr_flags_t       flags_v [N];
    logic [N-1:0]     elig_v;
    logic [N-1:0]     zero_next_v;
    logic [IDX_W-1:0] win_idx;
    logic             win_any;
    logic [1:0]       win_code;
    seq_state_e       seq_q;
    logic [IDX_W-1:0] owner_q;
    logic             err_q;

    for (genvar g = 0; g < N; g++) begin : g_req
        lockseq_outst_ctr #(.CNT_W(CNT_W)) ctr_i (
            .clk   (clk),
            .rst   (rst),
            .inc   (grant[g]),
            .dec   (txn_done[g]),
            .flags (flags_v[g])
        );

        assign zero_next_v[g] = flags_v[g].zero_next;

        // Open: anyone, but a lock opener needs an idle requester.
        // Held: only the owner. Drain: nobody.
        assign elig_v[g] = req_valid[g] && !flags_v[g].full &&
            (((seq_q == SEQ_OPEN) &&
              (!starts_lock(req_lock[2*g +: 2]) || flags_v[g].zero)) ||
             ((seq_q == SEQ_HELD) && (owner_q == IDX_W'(g))));
    end

    lockseq_rr_pick #(.N(N), .IDX_W(IDX_W)) pick_i (
        .clk     (clk),
        .rst     (rst),
        .elig    (elig_v),
        .gnt     (grant),
        .win_idx (win_idx),
        .win_any (win_any)
    );

    assign win_code = req_lock[2*int'(win_idx) +: 2];

    lockseq_seq_ctl #(.N(N), .IDX_W(IDX_W)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .win_any   (win_any),
        .win_idx   (win_idx),
        .win_code  (win_code),
        .zero_next (zero_next_v),
        .seq_q     (seq_q),
        .owner_q   (owner_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                                  err_q <= 1'b0;
        else if (win_any && is_reserved(win_code)) err_q <= 1'b1;
    end

    assign lock_held  = (seq_q != SEQ_OPEN);
    assign lock_owner = lock_held ? owner_q : '0;
    assign lock_err   = err_q;

endmodule

// File: rtl/lockseq_chk.sv
module lockseq_chk
    import lockseq_pkg::*;
#(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [N-1:0]     req_valid,
    input logic [2*N-1:0]   req_lock,
    input logic [N-1:0]     grant,
    input logic             lock_held,
    input logic [IDX_W-1:0] lock_owner,
    input logic             lock_err,
    input seq_state_e       seq_q
);
    logic [N-1:0] lk_vec;
    logic [N-1:0] own_mask;

    for (genvar g = 0; g < N; g++) begin : g_lk
        assign lk_vec[g] = (req_lock[2*g +: 2] == 2'b10);
    end

    assign own_mask = {{(N-1){1'b0}}, 1'b1} << lock_owner;

    assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_grant_needs_req_R1: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req_valid) == '0);

    assert_lock_opens_R4: assert property (@(posedge clk) disable iff (rst)
        (!lock_held && ((grant & lk_vec) != '0)) |=> lock_held);

    assert_only_owner_R5: assert property (@(posedge clk) disable iff (rst)
        lock_held |-> ((grant & ~own_mask) == '0));

    assert_owner_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (lock_held && $past(lock_held)) |-> $stable(lock_owner));

    assert_drain_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (seq_q == SEQ_DRAIN) |-> (grant == '0));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        lock_err |=> lock_err);

endmodule

bind lockseq_arbiter lockseq_chk #(.N(N), .IDX_W(IDX_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_lock   (req_lock),
    .grant      (grant),
    .lock_held  (lock_held),
    .lock_owner (lock_owner),
    .lock_err   (lock_err),
    .seq_q      (seq_q)
);

// File: tb/lockseq_arbiter_tb_top.sv
module lockseq_arbiter_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int N       = 4;
    localparam int CNT_W   = 3;
    localparam int IDX_W   = 2;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst;
    logic [N-1:0]     req_valid;
    logic [2*N-1:0]   req_lock;
    logic [N-1:0]     txn_done;
    logic [N-1:0]     grant;
    logic             lock_held;
    logic [IDX_W-1:0] lock_owner;
    logic             lock_err;

    always #10 clk = ~clk;

    lockseq_arbiter #(.N(N), .CNT_W(CNT_W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_lock   (req_lock),
        .txn_done   (txn_done),
        .grant      (grant),
        .lock_held  (lock_held),
        .lock_owner (lock_owner),
        .lock_err   (lock_err)
    );

    // Pending request codes per requester, front is offered.
    int rq [N][$];
    // Behavioural reference state.
    int m_cnt [N];
    int m_state;   // 0 open, 1 held, 2 drain
    int m_owner;
    int m_ptr;
    bit m_err;

    bit           auto_done;
    logic [N-1:0] force_done;
    string        tag;
    int           n_checks;
    int           n_fail;
    bit           finished;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit m_elig(input int i);
        int code;
        if (rq[i].size() == 0) return 1'b0;
        if (m_cnt[i] >= CNT_MAX) return 1'b0;
        code = rq[i][0];
        case (m_state)
            0:       return (code != 2) || (m_cnt[i] == 0);
            1:       return i == m_owner;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int m_pick();
        for (int off = 0; off < N; off++) begin
            if (m_elig((m_ptr + off) % N)) return (m_ptr + off) % N;
        end
        return -1;
    endfunction

    task automatic tick();
        int exp;
        int code;
        int exp_vec;
        int newc [N];
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            req_valid[i]      = (rq[i].size() > 0);
            req_lock[2*i +: 2] = (rq[i].size() > 0) ? 2'(rq[i][0]) : 2'b00;
            txn_done[i]       = force_done[i] ||
                                (auto_done && (m_cnt[i] > 0) && ($urandom % 3 == 0));
        end
        #2;
        exp     = m_pick();
        exp_vec = (exp >= 0) ? (1 << exp) : 0;
        check(int'(grant) == exp_vec, "grant", int'(grant), exp_vec);
        check(lock_held == (m_state != 0), "lock_held", int'(lock_held), int'(m_state != 0));
        check(int'(lock_owner) == ((m_state != 0) ? m_owner : 0), "lock_owner",
              int'(lock_owner), (m_state != 0) ? m_owner : 0);
        check(lock_err == m_err, "lock_err", int'(lock_err), int'(m_err));
        // Advance the model over the coming edge.
        code = (exp >= 0) ? rq[exp][0] : 0;
        for (int i = 0; i < N; i++) begin
            newc[i] = m_cnt[i] + ((i == exp) ? 1 : 0) - ((txn_done[i] && m_cnt[i] > 0) ? 1 : 0);
        end
        if (exp >= 0) begin
            m_ptr = (exp + 1) % N;
            if (code == 3) m_err = 1'b1;
        end
        case (m_state)
            0: if (exp >= 0 && code == 2) begin m_state = 1; m_owner = exp; end
            1: if (exp == m_owner && code != 2) m_state = 2;
            default: if (newc[m_owner] == 0) begin m_state = 0; m_owner = 0; end
        endcase
        for (int i = 0; i < N; i++) m_cnt[i] = newc[i];
        if (exp >= 0) void'(rq[exp].pop_front());
    endtask

    task automatic settle();
        auto_done = 1'b1;
        for (int k = 0; k < 200; k++) begin
            bit idle;
            idle = (m_state == 0);
            for (int i = 0; i < N; i++) idle &= (m_cnt[i] == 0) && (rq[i].size() == 0);
            if (idle) break;
            tick();
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20ns * 150000);
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        n_checks = 0; n_fail = 0; finished = 1'b0;
        auto_done = 1'b0; force_done = '0;
        m_state = 0; m_owner = 0; m_ptr = 0; m_err = 1'b0;
        for (int i = 0; i < N; i++) m_cnt[i] = 0;
        rst = 1'b1; req_valid = '0; req_lock = '0; txn_done = '0;
        repeat (3) @(posedge clk);
        #2;
        tag = "R11";
        check(grant == '0, "reset grant", int'(grant), 0);
        check(lock_held == 1'b0, "reset lock_held", int'(lock_held), 0);
        check(lock_owner == '0, "reset lock_owner", int'(lock_owner), 0);
        check(lock_err == 1'b0, "reset lock_err", int'(lock_err), 0);
        @(negedge clk);
        rst = 1'b0;

        // R1: lone plain request is accepted at once.
        tag = "R1";
        auto_done = 1'b1;
        rq[2].push_back(0);
        repeat (4) tick();
        settle();

        // R2: everyone asks twice, rotation visits them in turn.
        tag = "R2";
        for (int i = 0; i < N; i++) begin rq[i].push_back(0); rq[i].push_back(0); end
        repeat (12) tick();
        settle();

        // R10: exclusive behaves as plain, never locks.
        tag = "R10";
        rq[1].push_back(1); rq[1].push_back(1); rq[3].push_back(1); rq[0].push_back(0);
        for (int k = 0; k < 6; k++) begin
            tick();
            check(lock_held == 1'b0, "exclusive kept lock closed", int'(lock_held), 0);
        end
        settle();

        // R3: locked request waits for its own work to finish.
        tag = "R3";
        auto_done = 1'b0;
        rq[0].push_back(0);
        tick();
        rq[0].push_back(2); rq[1].push_back(0);
        for (int k = 0; k < 4; k++) begin
            tick();
            check(grant[0] == 1'b0, "locked held off while busy", int'(grant[0]), 0);
        end
        force_done = 4'b0001;
        tick();
        force_done = '0;

        // R4: the opening grant happens here, lock visible next cycle.
        tag = "R4";
        tick();
        tick();
        check(lock_held == 1'b1, "lock opened", int'(lock_held), 1);
        check(lock_owner == 2'd0, "lock owner", int'(lock_owner), 0);

        // R5: owner continues, others wait.
        tag = "R5";
        rq[2].push_back(0); rq[3].push_back(1);
        rq[0].push_back(2); rq[0].push_back(0);
        repeat (3) tick();

        // R6: after the closing grant nobody is served.
        tag = "R6";
        rq[0].push_back(0);
        for (int k = 0; k < 3; k++) begin
            tick();
            check(grant == '0, "no grant while draining", int'(grant), 0);
        end

        // R7: release follows the owner's last completion.
        tag = "R7";
        force_done = 4'b0001;
        repeat (3) tick();
        force_done = '0;
        tick();
        check(lock_held == 1'b0, "lock released", int'(lock_held), 0);
        settle();

        // R8: saturation, then surplus completions ignored.
        tag = "R8";
        auto_done = 1'b0;
        for (int k = 0; k < 9; k++) rq[3].push_back(0);
        repeat (10) tick();
        check(grant[3] == 1'b0, "full counter blocks grant", int'(grant[3]), 0);
        rq[3].delete();
        force_done = 4'b1000;
        repeat (9) tick();
        force_done = '0;
        rq[3].push_back(2);
        tick();
        check(grant[3] == 1'b1, "count floored at zero", int'(grant[3]), 1);
        rq[3].push_back(0);
        tick();
        settle();

        // R9: reserved code is served and flagged.
        tag = "R9";
        rq[1].push_back(3);
        repeat (3) tick();
        check(lock_err == 1'b1, "reserved sets error", int'(lock_err), 1);
        check(lock_held == 1'b0, "reserved does not lock", int'(lock_held), 0);
        settle();

        // Mixed traffic, model compared every cycle.
        tag = "R5";
        auto_done = 1'b1;
        for (int k = 0; k < 4000; k++) begin
            for (int i = 0; i < N; i++) begin
                if (rq[i].size() < 3 && ($urandom % 4 == 0)) begin
                    int r;
                    r = $urandom % 10;
                    rq[i].push_back((r < 5) ? 0 : (r < 7) ? 1 : (r < 9) ? 2 : 3);
                end
            end
            tick();
        end
        settle();
        summary();
    end

endmodule